// File: doc/BRIEF.md
# Shuffle-Exchange Self-Routing Interconnect

This block moves packets from N input ports to N output ports through a multistage network of 2x2 exchange elements. N is a power of two. In front of each stage the lines are rewired by a perfect shuffle. Every element steers a packet using one bit of the packet's destination address, so the network needs no central control. A packet presented in one cycle appears on its destination port in the next cycle. It carries its payload and the index of the port it came from.

The network has internal blocking. Two packets can need the same element output in the same cycle even when their destinations differ. When that happens, the packet on the upper input of the element keeps the output. The other packet is discarded, and the blocked flag of the input it entered on is raised in the same cycle in which delivered packets appear. The block has no buffering and no retry. A source that sees its blocked flag decides for itself whether to send again.

Top module: `omega_router`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, every out_valid_o and blocked_o bit is 0.
- R2: A valid packet on input s with destination d that is not blocked appears exactly one clock edge later on output d. At that point out_valid_o[d] is 1, out_src_o[d] equals s, and out_data_o[d] equals the payload.
- R3: When all N inputs are valid and each input's destination equals its own index, all N packets are delivered and no blocked bit is set.
- R4: When all N inputs are valid with the same destination d, exactly one packet is delivered, on output d, and the other N-1 blocked bits are set.
- R5: Stage k (k = 0 for the first stage) examines destination bit log2(N)-1-k, so the most significant bit is used first. A 0 steers the packet to the element's upper output (even line) and a 1 to its lower output (odd line). Before each stage, line j moves to line ((j<<1)|(j>>(log2(N)-1))) mod N.
- R6: When both inputs of an element request the same output, the packet on the upper (even) input line wins and the lower one is discarded.
- R7: Every valid input packet is accounted for exactly once. It is either delivered on one output or reported on blocked_o at its input index one cycle later.
- R8: An input with in_valid_i low is ignored. It claims no element output, cannot block another packet, and never raises its own blocked bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | N | Packet present on each input |
| in_dst_i | input | N x log2(N) | Destination port per input |
| in_data_i | input | N x DATA_W | Payload per input |
| out_valid_o | output | N | Packet delivered on each output |
| out_src_o | output | N x log2(N) | Source index of the delivered packet |
| out_data_o | output | N x DATA_W | Payload of the delivered packet |
| blocked_o | output | N | Packet from this input was discarded in the network |

## Verification
The assertions check four properties on every cycle. Each delivered packet must match the source, destination and payload that input had one cycle earlier. Delivered plus blocked must equal the number of valid inputs. Only valid inputs may be reported blocked. The two extreme traffic patterns (every input to itself, every input to one port) must give their known outcomes. The assertions cannot show which packet wins a given conflict, because that depends on the shuffle wiring and the bit order. The bench covers this by running single packets over every source and destination pair and many random mixed patterns, with each result compared against an independent stage-by-stage model of the network.

// File: rtl/omega_pkg.sv
package omega_pkg;
  // perfect shuffle: cyclic left rotate of a line index by one bit
  function automatic int shuffle_idx(int idx, int bits);
    return ((idx << 1) | (idx >> (bits - 1))) & ((1 << bits) - 1);
  endfunction
endpackage

// File: rtl/omega_switch.sv
module omega_switch #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int SEL    = 2
) (
  input  logic              up_v_i,
  input  logic [ADDR_W-1:0] up_dst_i,
  input  logic [ADDR_W-1:0] up_src_i,
  input  logic [DATA_W-1:0] up_data_i,
  input  logic              lo_v_i,
  input  logic [ADDR_W-1:0] lo_dst_i,
  input  logic [ADDR_W-1:0] lo_src_i,
  input  logic [DATA_W-1:0] lo_data_i,
  output logic [1:0]              o_v_o,
  output logic [1:0][ADDR_W-1:0]  o_dst_o,
  output logic [1:0][ADDR_W-1:0]  o_src_o,
  output logic [1:0][DATA_W-1:0]  o_data_o,
  output logic              drop_o,
  output logic [ADDR_W-1:0] drop_src_o
);
  logic up_bit, lo_bit;
  assign up_bit = up_dst_i[SEL];
  assign lo_bit = lo_dst_i[SEL];

  always_comb begin
    o_v_o      = '0;
    o_dst_o    = '0;
    o_src_o    = '0;
    o_data_o   = '0;
    drop_o     = 1'b0;
    drop_src_o = '0;
    if (up_v_i) begin
      o_v_o[up_bit]    = 1'b1;
      o_dst_o[up_bit]  = up_dst_i;
      o_src_o[up_bit]  = up_src_i;
      o_data_o[up_bit] = up_data_i;
    end
    if (lo_v_i) begin
      // upper input has fixed priority
      if (up_v_i && (up_bit == lo_bit)) begin
        drop_o     = 1'b1;
        drop_src_o = lo_src_i;
      end else begin
        o_v_o[lo_bit]    = 1'b1;
        o_dst_o[lo_bit]  = lo_dst_i;
        o_src_o[lo_bit]  = lo_src_i;
        o_data_o[lo_bit] = lo_data_i;
      end
    end
  end
endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int N_PORTS = 8,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int STAGE   = 0
) (
  input  logic [N_PORTS-1:0]             v_i,
  input  logic [N_PORTS-1:0][ADDR_W-1:0] dst_i,
  input  logic [N_PORTS-1:0][ADDR_W-1:0] src_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0] data_i,
  output logic [N_PORTS-1:0]             v_o,
  output logic [N_PORTS-1:0][ADDR_W-1:0] dst_o,
  output logic [N_PORTS-1:0][ADDR_W-1:0] src_o,
  output logic [N_PORTS-1:0][DATA_W-1:0] data_o,
  output logic [N_PORTS-1:0]             blk_o
);
  import omega_pkg::*;
  localparam int N_SW = N_PORTS / 2;
  localparam int SEL  = ADDR_W - 1 - STAGE;

  logic [N_PORTS-1:0]             sh_v;
  logic [N_PORTS-1:0][ADDR_W-1:0] sh_dst, sh_src;
  logic [N_PORTS-1:0][DATA_W-1:0] sh_data;
  logic [N_SW-1:0]                drop;
  logic [N_SW-1:0][ADDR_W-1:0]    drop_src;

  for (genvar j = 0; j < N_PORTS; j++) begin : g_shuf
    localparam int TO = shuffle_idx(j, ADDR_W);
    assign sh_v[TO]    = v_i[j];
    assign sh_dst[TO]  = dst_i[j];
    assign sh_src[TO]  = src_i[j];
    assign sh_data[TO] = data_i[j];
  end

  for (genvar k = 0; k < N_SW; k++) begin : g_sw
    omega_switch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL(SEL)) i_sw (
      .up_v_i    (sh_v[2*k]),
      .up_dst_i  (sh_dst[2*k]),
      .up_src_i  (sh_src[2*k]),
      .up_data_i (sh_data[2*k]),
      .lo_v_i    (sh_v[2*k+1]),
      .lo_dst_i  (sh_dst[2*k+1]),
      .lo_src_i  (sh_src[2*k+1]),
      .lo_data_i (sh_data[2*k+1]),
      .o_v_o     (v_o[2*k+1:2*k]),
      .o_dst_o   (dst_o[2*k+1:2*k]),
      .o_src_o   (src_o[2*k+1:2*k]),
      .o_data_o  (data_o[2*k+1:2*k]),
      .drop_o    (drop[k]),
      .drop_src_o(drop_src[k])
    );
  end

  always_comb begin
    blk_o = '0;
    for (int k = 0; k < N_SW; k++)
      if (drop[k]) blk_o[drop_src[k]] = 1'b1;
  end
endmodule

// File: rtl/omega_router.sv
module omega_router #(
  parameter int N_PORTS = 8,
  parameter int DATA_W  = 8,
  localparam int ADDR_W = $clog2(N_PORTS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_PORTS-1:0]             in_valid_i,
  input  logic [N_PORTS-1:0][ADDR_W-1:0] in_dst_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0] in_data_i,
  output logic [N_PORTS-1:0]             out_valid_o,
  output logic [N_PORTS-1:0][ADDR_W-1:0] out_src_o,
  output logic [N_PORTS-1:0][DATA_W-1:0] out_data_o,
  output logic [N_PORTS-1:0]             blocked_o
);
  localparam int STAGES = ADDR_W;

  logic [STAGES:0][N_PORTS-1:0]             v;
  logic [STAGES:0][N_PORTS-1:0][ADDR_W-1:0] dst, src;
  logic [STAGES:0][N_PORTS-1:0][DATA_W-1:0] data;
  logic [STAGES-1:0][N_PORTS-1:0]           blk;
  logic [N_PORTS-1:0]                       blk_any;

  assign v[0]    = in_valid_i;
  assign dst[0]  = in_dst_i;
  assign data[0] = in_data_i;
  for (genvar i = 0; i < N_PORTS; i++) begin : g_src
    assign src[0][i] = ADDR_W'(i);
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    omega_stage #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAGE(s)) i_stage (
      .v_i   (v[s]),
      .dst_i (dst[s]),
      .src_i (src[s]),
      .data_i(data[s]),
      .v_o   (v[s+1]),
      .dst_o (dst[s+1]),
      .src_o (src[s+1]),
      .data_o(data[s+1]),
      .blk_o (blk[s])
    );
  end

  always_comb begin
    blk_any = '0;
    for (int s = 0; s < STAGES; s++) blk_any |= blk[s];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= '0;
      out_src_o   <= '0;
      out_data_o  <= '0;
      blocked_o   <= '0;
    end else begin
      out_valid_o <= v[STAGES];
      out_src_o   <= src[STAGES];
      out_data_o  <= data[STAGES];
      blocked_o   <= blk_any;
    end
  end

  // ---- assertions ----
  function automatic logic all_self(logic [N_PORTS-1:0] vv, logic [N_PORTS-1:0][ADDR_W-1:0] dd);
    logic r = &vv;
    for (int i = 0; i < N_PORTS; i++) if (dd[i] != ADDR_W'(i)) r = 1'b0;
    return r;
  endfunction

  function automatic logic all_same(logic [N_PORTS-1:0] vv, logic [N_PORTS-1:0][ADDR_W-1:0] dd);
    logic r = &vv;
    for (int i = 1; i < N_PORTS; i++) if (dd[i] != dd[0]) r = 1'b0;
    return r;
  endfunction

  a_r7_conservation: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(out_valid_o) + $countones(blocked_o)) == $countones($past(in_valid_i)));

  a_r3_identity_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(all_self(in_valid_i, in_dst_i)) |-> (blocked_o == '0) && (&out_valid_o));

  a_r4_single_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(all_same(in_valid_i, in_dst_i)) |-> ($countones(out_valid_o) == 1)
      && out_valid_o[$past(in_dst_i[0])]);

  for (genvar s = 0; s < N_PORTS; s++) begin : g_chk_src
    a_r8_blocked_valid_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      blocked_o[s] |-> $past(in_valid_i[s]));
    for (genvar d = 0; d < N_PORTS; d++) begin : g_chk_dst
      a_r2_delivery_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o[d] && out_src_o[d] == ADDR_W'(s)) |->
          ($past(in_valid_i[s]) && $past(in_dst_i[s]) == ADDR_W'(d)
           && out_data_o[d] == $past(in_data_i[s]) && !blocked_o[s]));
    end
  end
endmodule

// File: tb/test_omega_router.sv
module test_omega_router;
  localparam int N = 8;
  localparam int A = 3;
  localparam int D = 8;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [N-1:0]          in_valid;
  logic [N-1:0][A-1:0]   in_dst;
  logic [N-1:0][D-1:0]   in_data;
  logic [N-1:0]          out_valid;
  logic [N-1:0][A-1:0]   out_src;
  logic [N-1:0][D-1:0]   out_data;
  logic [N-1:0]          blocked;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  omega_router #(.N_PORTS(N), .DATA_W(D)) i_omega_router (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_dst_i(in_dst), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_src_o(out_src), .out_data_o(out_data),
    .blocked_o(blocked)
  );

  // expected results from the reference model
  int exp_v[N];
  int exp_src[N];
  int exp_blk[N];

  function automatic int rotl(int j);
    return ((j << 1) | (j >> (A - 1))) & (N - 1);
  endfunction

  // stage-by-stage model: shuffle, then steer by dst bit MSB first, upper line wins (R5, R6)
  task automatic run_model();
    int lv[N], ls[N], nv[N], ns[N];
    for (int j = 0; j < N; j++) begin
      lv[j] = int'(in_valid[j]); ls[j] = j; exp_blk[j] = 0;
    end
    for (int s = 0; s < A; s++) begin
      for (int j = 0; j < N; j++) begin
        nv[rotl(j)] = lv[j]; ns[rotl(j)] = ls[j];
      end
      for (int j = 0; j < N; j++) begin lv[j] = 0; ls[j] = 0; end
      for (int j = 0; j < N; j++) begin
        if (nv[j] != 0) begin
          int b;
          int t;
          b = (int'(in_dst[ns[j]]) >> (A - 1 - s)) & 1;
          t = (j & ~1) | b;
          if (lv[t] != 0) exp_blk[ns[j]] = 1;
          else begin lv[t] = 1; ls[t] = ns[j]; end
        end
      end
    end
    for (int j = 0; j < N; j++) begin exp_v[j] = lv[j]; exp_src[j] = ls[j]; end
  endtask

  task automatic check(string req, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // apply inputs on a falling edge, check outputs at the next falling edge
  task automatic apply_and_compare(string req);
    run_model();
    @(negedge clk);
    for (int j = 0; j < N; j++) begin
      check(req, int'(out_valid[j]), exp_v[j], $sformatf("out_valid[%0d]", j));
      if (exp_v[j] != 0 && out_valid[j]) begin
        check(req, int'(out_src[j]), exp_src[j], $sformatf("out_src[%0d]", j));
        check(req, int'(out_data[j]), int'(in_data[exp_src[j]]), $sformatf("out_data[%0d]", j));
      end
      check(req, int'(blocked[j]), exp_blk[j], $sformatf("blocked[%0d]", j));
    end
  endtask

  task automatic set_data_random();
    for (int i = 0; i < N; i++) in_data[i] = D'($urandom);
  endtask

  initial begin
    in_valid = '0; in_dst = '0; in_data = '0;
    #23;
    // R1: reset state
    check("R1", int'(out_valid), 0, "out_valid in reset");
    check("R1", int'(blocked), 0, "blocked in reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(out_valid), 0, "out_valid after reset");
    check("R1", int'(blocked), 0, "blocked after reset");

    // R3: every input to itself
    in_valid = '1; set_data_random();
    for (int i = 0; i < N; i++) in_dst[i] = A'(i);
    apply_and_compare("R3");
    check("R3", int'(blocked), 0, "identity blocked vector");

    // R4: every input to one destination
    for (int d = 0; d < N; d++) begin
      in_valid = '1; set_data_random();
      for (int i = 0; i < N; i++) in_dst[i] = A'(d);
      apply_and_compare("R4");
      check("R4", $countones(out_valid), 1, "hotspot delivered count");
      check("R4", int'(out_valid[d]), 1, "hotspot port valid");
      check("R4", $countones(blocked), N - 1, "hotspot blocked count");
    end

    // R2, R5: single packet over every source/destination pair
    for (int s = 0; s < N; s++) begin
      for (int d = 0; d < N; d++) begin
        in_valid = '0; in_valid[s] = 1'b1; set_data_random();
        for (int i = 0; i < N; i++) in_dst[i] = A'($urandom);
        in_dst[s] = A'(d);
        apply_and_compare("R2");
        check("R5", int'(out_valid[d]), 1, "lone packet at its dst");
      end
    end

    // R8: invalid inputs all aimed at port 0 must not block the single valid one
    for (int s = 0; s < N; s++) begin
      in_valid = '0; in_valid[s] = 1'b1; set_data_random();
      for (int i = 0; i < N; i++) in_dst[i] = '0;
      apply_and_compare("R8");
      check("R8", int'(blocked), 0, "no blocked with idle neighbours");
      check("R8", int'(out_src[0]), s, "lone winner source");
    end

    // R6, R7: random mixed traffic against the model
    for (int n = 0; n < 300; n++) begin
      in_valid = N'($urandom); set_data_random();
      for (int i = 0; i < N; i++) in_dst[i] = A'($urandom);
      apply_and_compare("R6");
      check("R7", $countones(out_valid) + $countones(blocked), $countones(in_valid),
            "delivered plus blocked");
    end

    // R6: cyclic shifts by every amount
    for (int k = 0; k < N; k++) begin
      in_valid = '1; set_data_random();
      for (int i = 0; i < N; i++) in_dst[i] = A'((i + k) % N);
      apply_and_compare("R6");
    end

    in_valid = '0;
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule